// File: doc/BRIEF.md
# Boost Start-up and Fault Sequencer

This block is the digital supervisor of a boost regulator. An active-low enable input starts a fixed soft-start. The inductor path is first pre-charged through a current-limited input switch. The input switch then closes fully. The switching driver then runs with its peak-current limit raised in quarter steps until it reaches full strength. Every timed stage is measured in pulses of a timing tick, so the stage lengths do not depend on the system clock rate.

While the soft-start runs, or once it has finished, four fault flags are watched on every clock: supply undervoltage, overcurrent in the input switch, output overvoltage and over-temperature. Each fault class has its own recovery rule. An overcurrent restarts the soft-start at once. Each of the other three faults parks the block in its own wait state, with every output off, until the matching recovery flag arrives. The analog comparators and the PWM generator are outside this block. The flags are expected as clean, clock-synchronous levels. Only the enable input is taken asynchronously.

Top module: `boost_startup_seq`

## Requirements
- R1: After reset, and whenever the block is disabled, `stateCode` is 0 and `inrushEn`, `swEn`, `drvEn` and `ilimLvl` are all 0. The state codes are: 0 off, 1 pre-charge, 2 switch-on, 3 boost-25, 4 boost-50, 5 boost-75, 6 full-run, 7 wait-supply, 8 wait-output-drop, 9 wait-cool.
- R2: `enN` passes through a two-flop synchronizer. When `enN` is driven low, with the block in state 0, the state becomes 1 on the third rising clock edge after the change and not before.
- R3: Only cycles with `tick` high count toward a stage's length. The stages 1, 3, 4 and 5 last LONG_TICKS ticks each (default 2048), and stage 2 lasts SHORT_TICKS ticks (default 128). The stages run in the order 1, 2, 3, 4, 5, 6. The tick count restarts from zero on every stage entry.
- R4: Outputs by state. In 1 only `inrushEn` is high. In 2 only `swEn` is high. In states 3 to 6 both `swEn` and `drvEn` are high, with `ilimLvl` equal to 0, 1, 2 and 3 (meaning 25, 50, 75 and 100 percent). `ilimLvl` is 0 whenever `drvEn` is low.
- R5: State 6 is held for as long as the synchronized enable is active and no fault flag is high.
- R6: A synchronized enable that has gone inactive sends the block to state 0 on the next edge from any state. This takes precedence over every fault flag and every recovery flag.
- R7: `fltOc` high in any of the states 1 to 6, with no higher-priority fault, returns the block to state 1 on the next edge. The pre-charge tick count restarts, including when the block was already in state 1.
- R8: `fltUv` high in any of the states 1 to 6 moves the block to state 7. It stays there, with all outputs off, until `rcvSupply` is high, and then moves to state 1.
- R9: `fltOv` leads to state 8, which is left for state 1 only on `rcvOutLow`. `fltOt` leads to state 9, which is left for state 1 only on `rcvCool`. A recovery flag that does not match the current wait state has no effect.
- R10: When several fault flags are high together, the one followed is the highest in this ranking: `fltUv`, then `fltOt`, then `fltOv`, then `fltOc`.
- R11: Fault flags have no effect in state 0 or in the wait states 7 to 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enN | input | 1 | Active-low run request, asynchronous |
| tick | input | 1 | Timing pulse, one clock wide |
| fltUv | input | 1 | Supply undervoltage flag |
| fltOc | input | 1 | Input-switch overcurrent flag |
| fltOv | input | 1 | Output overvoltage flag |
| fltOt | input | 1 | Over-temperature flag |
| rcvSupply | input | 1 | Supply is back above its turn-on level |
| rcvOutLow | input | 1 | Output has fallen back below its limit |
| rcvCool | input | 1 | Die has cooled below its restart level |
| inrushEn | output | 1 | Input switch in limited-current pre-charge mode |
| swEn | output | 1 | Input switch fully on |
| drvEn | output | 1 | Switching driver enable |
| ilimLvl | output | 2 | Current-limit step, 0..3 for 25..100 percent |
| stateCode | output | 4 | Current sequencer state |

## Verification
The properties assume that the fault flags, the recovery flags and `tick` are synchronous to `clk`. Their fault and enable properties are stated against the internal synchronized run request, not against the raw `enN` pin. The stimulus changes every input only on the falling clock edge, so each flag is a stable level at the next rising edge. The bench shortens the stage lengths through the parameters. It drives the tick both every cycle and every third cycle, so that counting only on ticks is observed.

// File: rtl/boost_seq_pkg.sv
package boost_seq_pkg;

  typedef enum logic [3:0] {
    ST_OFF    = 4'd0,
    ST_PRECHG = 4'd1,
    ST_SWON   = 4'd2,
    ST_B25    = 4'd3,
    ST_B50    = 4'd4,
    ST_B75    = 4'd5,
    ST_RUN    = 4'd6,
    ST_WSUP   = 4'd7,
    ST_WDROP  = 4'd8,
    ST_WCOOL  = 4'd9
  } seqState_t;

  // strobes from control to the timing datapath
  typedef struct packed {
    logic cntClr;
    logic cntRun;
    logic shortSel;
  } timerCmd_t;

endpackage

// File: rtl/boost_seq_timer.sv
module boost_seq_timer
  import boost_seq_pkg::*;
#(
  parameter int LONG_TICKS  = 2048,
  parameter int SHORT_TICKS = 128,
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      enN,
  input  logic      tick,
  input  timerCmd_t cmd,
  output logic      runReq,
  output logic      expire
);
  localparam int CW = (LONG_TICKS > 1) ? $clog2(LONG_TICKS) : 1;
  localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_TICKS - 1);
  localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_TICKS - 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [CW-1:0]          tickCnt;
  logic [CW-1:0]          lastCnt;

  // enable synchronizer; resets to "not running"
  generate
    if (SYNC_STAGES > 1) begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], ~enN};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= ~enN;
      end
    end
  endgenerate

  assign runReq  = syncQ[SYNC_STAGES-1];
  assign lastCnt = cmd.shortSel ? SHORT_LAST : LONG_LAST;
  assign expire  = cmd.cntRun && tick && (tickCnt == lastCnt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  tickCnt <= '0;
    else if (cmd.cntClr)        tickCnt <= '0;
    else if (cmd.cntRun && tick) tickCnt <= tickCnt + CW'(1);
  end

endmodule

// File: rtl/boost_seq_ctrl.sv
module boost_seq_ctrl
  import boost_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       runReq,
  input  logic       expire,
  input  logic       fltUv,
  input  logic       fltOc,
  input  logic       fltOv,
  input  logic       fltOt,
  input  logic       rcvSupply,
  input  logic       rcvOutLow,
  input  logic       rcvCool,
  output timerCmd_t  cmd,
  output logic       inrushEn,
  output logic       swEn,
  output logic       drvEn,
  output logic [1:0] ilimLvl,
  output logic [3:0] stateCode
);
  seqState_t state, nxt;
  logic      restart;

  always_comb begin
    nxt     = state;
    restart = 1'b0;
    if (!runReq) begin
      nxt = ST_OFF;
    end else begin
      unique case (state)
        ST_OFF:   nxt = ST_PRECHG;
        ST_WSUP:  if (rcvSupply) nxt = ST_PRECHG;
        ST_WDROP: if (rcvOutLow) nxt = ST_PRECHG;
        ST_WCOOL: if (rcvCool)   nxt = ST_PRECHG;
        ST_PRECHG, ST_SWON, ST_B25, ST_B50, ST_B75, ST_RUN: begin
          if      (fltUv) nxt = ST_WSUP;
          else if (fltOt) nxt = ST_WCOOL;
          else if (fltOv) nxt = ST_WDROP;
          else if (fltOc) begin
            nxt     = ST_PRECHG;
            restart = 1'b1;
          end else if (expire) begin
            unique case (state)
              ST_PRECHG: nxt = ST_SWON;
              ST_SWON:   nxt = ST_B25;
              ST_B25:    nxt = ST_B50;
              ST_B50:    nxt = ST_B75;
              ST_B75:    nxt = ST_RUN;
              default:   nxt = state;
            endcase
          end
        end
        default:  nxt = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OFF;
    else       state <= nxt;
  end

  assign cmd.cntClr   = (nxt != state) || restart;
  assign cmd.cntRun   = state inside {ST_PRECHG, ST_SWON, ST_B25, ST_B50, ST_B75};
  assign cmd.shortSel = (state == ST_SWON);

  assign inrushEn  = (state == ST_PRECHG);
  assign swEn      = state inside {ST_SWON, ST_B25, ST_B50, ST_B75, ST_RUN};
  assign drvEn     = state inside {ST_B25, ST_B50, ST_B75, ST_RUN};
  assign stateCode = state;

  always_comb begin
    unique case (state)
      ST_B50:  ilimLvl = 2'd1;
      ST_B75:  ilimLvl = 2'd2;
      ST_RUN:  ilimLvl = 2'd3;
      default: ilimLvl = 2'd0;
    endcase
  end

endmodule

// File: rtl/boost_startup_seq.sv
module boost_startup_seq
  import boost_seq_pkg::*;
#(
  parameter int LONG_TICKS  = 2048,
  parameter int SHORT_TICKS = 128
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enN,
  input  logic       tick,
  input  logic       fltUv,
  input  logic       fltOc,
  input  logic       fltOv,
  input  logic       fltOt,
  input  logic       rcvSupply,
  input  logic       rcvOutLow,
  input  logic       rcvCool,
  output logic       inrushEn,
  output logic       swEn,
  output logic       drvEn,
  output logic [1:0] ilimLvl,
  output logic [3:0] stateCode
);
  timerCmd_t timerCmd;
  logic      runReq;
  logic      expire;

  boost_seq_timer #(
    .LONG_TICKS (LONG_TICKS),
    .SHORT_TICKS(SHORT_TICKS),
    .SYNC_STAGES(2)
  ) timer_i (
    .clk   (clk),
    .rstN  (rstN),
    .enN   (enN),
    .tick  (tick),
    .cmd   (timerCmd),
    .runReq(runReq),
    .expire(expire)
  );

  boost_seq_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .runReq   (runReq),
    .expire   (expire),
    .fltUv    (fltUv),
    .fltOc    (fltOc),
    .fltOv    (fltOv),
    .fltOt    (fltOt),
    .rcvSupply(rcvSupply),
    .rcvOutLow(rcvOutLow),
    .rcvCool  (rcvCool),
    .cmd      (timerCmd),
    .inrushEn (inrushEn),
    .swEn     (swEn),
    .drvEn    (drvEn),
    .ilimLvl  (ilimLvl),
    .stateCode(stateCode)
  );

endmodule

// File: rtl/boost_seq_chk.sv
module boost_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       runReq,
  input logic       fltUv,
  input logic       fltOc,
  input logic       fltOv,
  input logic       fltOt,
  input logic       rcvSupply,
  input logic       inrushEn,
  input logic       swEn,
  input logic       drvEn,
  input logic [1:0] ilimLvl,
  input logic [3:0] stateCode
);
  logic actSt;
  assign actSt = (stateCode >= 4'd1) && (stateCode <= 4'd6);

  p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 4'd0) |-> (!inrushEn && !swEn && !drvEn && ilimLvl == 2'd0));

  p_drv_needs_sw_r4: assert property (@(posedge clk) disable iff (!rstN)
    drvEn |-> (swEn && !inrushEn));

  p_ilim_zero_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    !drvEn |-> (ilimLvl == 2'd0));

  p_run_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 4'd6 && runReq && !fltUv && !fltOc && !fltOv && !fltOt)
      |=> (stateCode == 4'd6));

  p_disable_wins_r6: assert property (@(posedge clk) disable iff (!rstN)
    !runReq |=> (stateCode == 4'd0));

  p_oc_restart_r7: assert property (@(posedge clk) disable iff (!rstN)
    (actSt && runReq && fltOc && !fltUv && !fltOt && !fltOv) |=> (stateCode == 4'd1));

  p_uv_park_r8: assert property (@(posedge clk) disable iff (!rstN)
    (actSt && runReq && fltUv) |=> (stateCode == 4'd7));

  p_uv_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 4'd7 && runReq && !rcvSupply) |=> (stateCode == 4'd7));

endmodule

bind boost_startup_seq boost_seq_chk chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .runReq   (runReq),
  .fltUv    (fltUv),
  .fltOc    (fltOc),
  .fltOv    (fltOv),
  .fltOt    (fltOt),
  .rcvSupply(rcvSupply),
  .inrushEn (inrushEn),
  .swEn     (swEn),
  .drvEn    (drvEn),
  .ilimLvl  (ilimLvl),
  .stateCode(stateCode)
);

// File: tb/boost_startup_seq_tb.sv
module boost_startup_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LONG_T  = 40;
  localparam int SHORT_T = 6;
  localparam int WDOG    = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enN = 1'b1;
  logic tick = 1'b0;
  logic fltUv = 0, fltOc = 0, fltOv = 0, fltOt = 0;
  logic rcvSupply = 0, rcvOutLow = 0, rcvCool = 0;
  logic inrushEn, swEn, drvEn;
  logic [1:0] ilimLvl;
  logic [3:0] stateCode;

  int nChk = 0, nFail = 0, cyc = 0;
  bit finished = 0;
  string phaseTag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  boost_startup_seq #(.LONG_TICKS(LONG_T), .SHORT_TICKS(SHORT_T)) dut_i (
    .clk(clk), .rstN(rstN), .enN(enN), .tick(tick),
    .fltUv(fltUv), .fltOc(fltOc), .fltOv(fltOv), .fltOt(fltOt),
    .rcvSupply(rcvSupply), .rcvOutLow(rcvOutLow), .rcvCool(rcvCool),
    .inrushEn(inrushEn), .swEn(swEn), .drvEn(drvEn),
    .ilimLvl(ilimLvl), .stateCode(stateCode)
  );

  // behavioural reference model
  int  mSt = 0, mCnt = 0;
  bit  s1 = 0, s2 = 0;

  function automatic int stageLen(int st);
    return (st == 2) ? SHORT_T : LONG_T;
  endfunction

  always @(posedge clk) begin
    int nx;
    bit rs;
    if (!rstN) begin
      mSt = 0; mCnt = 0; s1 = 0; s2 = 0;
    end else begin
      nx = mSt; rs = 0;
      if (!s2) nx = 0;
      else if (mSt == 0) nx = 1;
      else if (mSt == 7) begin if (rcvSupply) nx = 1; end
      else if (mSt == 8) begin if (rcvOutLow) nx = 1; end
      else if (mSt == 9) begin if (rcvCool) nx = 1; end
      else begin
        if (fltUv) nx = 7;
        else if (fltOt) nx = 9;
        else if (fltOv) nx = 8;
        else if (fltOc) begin nx = 1; rs = 1; end
        else if (mSt <= 5 && tick) begin
          if (mCnt == stageLen(mSt) - 1) nx = mSt + 1;
          else mCnt++;
        end
      end
      if (nx != mSt || rs) mCnt = 0;
      mSt = nx;
      s2 = s1;
      s1 = !enN;
    end
  end

  task automatic checkEq(string tag, string what, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic compareModel();
    int eIn, eSw, eDrv, eLim;
    eIn  = (mSt == 1);
    eSw  = (mSt >= 2 && mSt <= 6);
    eDrv = (mSt >= 3 && mSt <= 6);
    eLim = (mSt == 4) ? 1 : (mSt == 5) ? 2 : (mSt == 6) ? 3 : 0;
    checkEq(phaseTag, "stateCode", int'(stateCode), mSt);
    checkEq("R4", "inrushEn", int'(inrushEn), eIn);
    checkEq("R4", "swEn", int'(swEn), eSw);
    checkEq("R4", "drvEn", int'(drvEn), eDrv);
    checkEq("R4", "ilimLvl", int'(ilimLvl), eLim);
  endtask

  task automatic step(int n, int period = 1);
    for (int k = 0; k < n; k++) begin
      tick = ((cyc % period) == 0);
      @(negedge clk);
      compareModel();
    end
  endtask

  task automatic waitState(int target, int period = 1);
    for (int k = 0; k < 20000 && stateCode != 4'(target); k++) step(1, period);
    checkEq(phaseTag, "reached state", int'(stateCode), target);
  endtask

  task automatic restartSeq();
    enN = 1'b1; step(4);
    enN = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG && !finished) begin
      finished = 1;
      nFail++; nChk++;
      $display("FAIL watchdog R1 actual %0d cycles expected under %0d", cyc, WDOG);
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    step(1);
    // r1_ reset state
    checkEq("R1", "reset state", int'(stateCode), 0);
    checkEq("R1", "reset outputs", int'({inrushEn, swEn, drvEn, ilimLvl}), 0);

    // R11: fault flags in state 0 change nothing
    phaseTag = "R11";
    fltUv = 1; fltOt = 1; step(4);
    checkEq("R11", "off with faults", int'(stateCode), 0);
    fltUv = 0; fltOt = 0;

    // R2 synchronizer latency, R3 durations, R4 outputs
    phaseTag = "R2";
    enN = 1'b0;
    step(2); checkEq("R2", "still off after 2 edges", int'(stateCode), 0);
    step(1); checkEq("R2", "precharge on 3rd edge", int'(stateCode), 1);
    checkEq("R4", "inrush only", int'({inrushEn, swEn, drvEn}), 3'b100);
    phaseTag = "R3";
    step(LONG_T - 1); checkEq("R3", "precharge length", int'(stateCode), 1);
    step(1);          checkEq("R3", "switch-on entered", int'(stateCode), 2);
    checkEq("R4", "switch only", int'({inrushEn, swEn, drvEn}), 3'b010);
    step(SHORT_T - 1); checkEq("R3", "switch-on length", int'(stateCode), 2);
    step(1);           checkEq("R3", "boost25 entered", int'(stateCode), 3);
    checkEq("R4", "ilim 25", int'(ilimLvl), 0);
    step(LONG_T); checkEq("R3", "boost50 entered", int'(stateCode), 4);
    checkEq("R4", "ilim 50", int'(ilimLvl), 1);
    step(LONG_T); checkEq("R3", "boost75 entered", int'(stateCode), 5);
    checkEq("R4", "ilim 75", int'(ilimLvl), 2);
    step(LONG_T); checkEq("R3", "full run entered", int'(stateCode), 6);
    checkEq("R4", "ilim 100", int'(ilimLvl), 3);
    phaseTag = "R5";
    step(60); checkEq("R5", "full run held", int'(stateCode), 6);

    // R6 disable
    phaseTag = "R6";
    enN = 1'b1;
    step(2); checkEq("R6", "run before sync", int'(stateCode), 6);
    step(1); checkEq("R6", "off after disable", int'(stateCode), 0);
    checkEq("R6", "outputs off", int'({inrushEn, swEn, drvEn, ilimLvl}), 0);

    // R3 sparse ticks
    phaseTag = "R3";
    enN = 1'b0;
    waitState(6, 3);
    restartSeq();

    // R7 overcurrent restarts and clears the count
    phaseTag = "R7";
    step(3 + 10);
    checkEq("R7", "in precharge", int'(stateCode), 1);
    fltOc = 1; step(1); fltOc = 0;
    checkEq("R7", "oc in precharge stays", int'(stateCode), 1);
    step(LONG_T - 1); checkEq("R7", "count restarted", int'(stateCode), 1);
    step(1);          checkEq("R7", "then switch-on", int'(stateCode), 2);
    waitState(4);
    step(5);
    fltOc = 1; step(1); fltOc = 0;
    checkEq("R7", "oc from boost50", int'(stateCode), 1);

    // R8 undervoltage
    phaseTag = "R8";
    waitState(6);
    fltUv = 1; step(1); fltUv = 0;
    checkEq("R8", "uv wait", int'(stateCode), 7);
    checkEq("R8", "uv outputs off", int'({inrushEn, swEn, drvEn, ilimLvl}), 0);
    phaseTag = "R9";
    rcvOutLow = 1; rcvCool = 1; step(5); rcvOutLow = 0; rcvCool = 0;
    checkEq("R9", "wrong recovery ignored", int'(stateCode), 7);
    phaseTag = "R11";
    fltOc = 1; fltOv = 1; step(3); fltOc = 0; fltOv = 0;
    checkEq("R11", "faults ignored in wait", int'(stateCode), 7);
    phaseTag = "R8";
    rcvSupply = 1; step(1); rcvSupply = 0;
    checkEq("R8", "supply recovery", int'(stateCode), 1);

    // R9 overvoltage and over-temperature
    phaseTag = "R9";
    waitState(6);
    fltOv = 1; step(1); fltOv = 0;
    checkEq("R9", "ov wait", int'(stateCode), 8);
    rcvSupply = 1; rcvCool = 1; step(4); rcvSupply = 0; rcvCool = 0;
    checkEq("R9", "ov ignores others", int'(stateCode), 8);
    rcvOutLow = 1; step(1); rcvOutLow = 0;
    checkEq("R9", "ov recovery", int'(stateCode), 1);
    waitState(3);
    fltOt = 1; step(1); fltOt = 0;
    checkEq("R9", "ot wait", int'(stateCode), 9);
    rcvOutLow = 1; rcvSupply = 1; step(4); rcvOutLow = 0; rcvSupply = 0;
    checkEq("R9", "ot ignores others", int'(stateCode), 9);
    rcvCool = 1; step(1); rcvCool = 0;
    checkEq("R9", "ot recovery", int'(stateCode), 1);

    // R10 priority
    phaseTag = "R10";
    waitState(2);
    fltUv = 1; fltOt = 1; fltOv = 1; fltOc = 1; step(1);
    fltUv = 0; fltOt = 0; fltOv = 0; fltOc = 0;
    checkEq("R10", "uv wins", int'(stateCode), 7);
    rcvSupply = 1; step(1); rcvSupply = 0;
    fltOt = 1; fltOv = 1; fltOc = 1; step(1);
    fltOt = 0; fltOv = 0; fltOc = 0;
    checkEq("R10", "ot over ov/oc", int'(stateCode), 9);
    rcvCool = 1; step(1); rcvCool = 0;
    fltOv = 1; fltOc = 1; step(1); fltOv = 0; fltOc = 0;
    checkEq("R10", "ov over oc", int'(stateCode), 8);
    rcvOutLow = 1; step(1); rcvOutLow = 0;

    // R6 disable overrides wait and recovery
    phaseTag = "R6";
    fltUv = 1; enN = 1'b1; step(1); fltUv = 0;
    checkEq("R6", "fault before sync", int'(stateCode), 7);
    rcvSupply = 1; step(2); rcvSupply = 0;
    checkEq("R6", "disable beats recovery", int'(stateCode), 0);
    step(3);

    finished = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule